// File: doc/BRIEF.md
# Double-Data-Rate Link Word Serializer

This block turns three 10-bit channel symbols per pixel period into serial bit streams for a DVI-D style link. It also generates a fourth, clock-carrying lane. It runs on a fast clock at five times the pixel rate. Every lane delivers two bits in each fast cycle. The first bit of the pair is meant for the rising edge of an external double-data-rate output register. The second bit is meant for its falling edge, or for the capture edge of the inverted fast clock. Five fast cycles therefore carry one whole symbol, which gives a serial rate of ten bits per pixel period.

A modulo-5 slot counter frames the symbols. When the counter reaches its last slot, each lane register takes a new word. The word comes from the pixel-domain inputs for the data lanes and from a fixed pattern for the clock lane. On every other fast cycle the register moves two places toward the least significant end. The pixel clock is assumed to be phase-related to the fast clock, so the inputs only need to be stable during the last slot of each pixel period.

Top module: `tmds_ddr_serializer`

## Requirements
- R1: While `rst` is high, and during the first four fast cycles after it falls, all four pair outputs read `00`.
- R2: The slot counter counts 0,1,2,3,4,0,... after reset. The first word is taken on the fifth rising fast-clock edge after reset is released, which is the first wrap.
- R3: Bits leave least significant first. In slot k (k = 0..4) of a symbol, bit 0 of the pair (rising-edge slot) is word bit 2k and bit 1 of the pair (falling-edge slot) is word bit 2k+1.
- R4: The value on a data input at the rising edge that ends slot 4 appears on that lane's pair output during the next five fast cycles. This is a latency of exactly one pixel period.
- R5: The clock lane sends the serial pattern 0000011111 (first bit first) in every symbol. Its pairs in slots 0..4 are `00`, `00`, `10`, `11`, `11`.
- R6: The blue, green and red lanes (inputs `word_b`, `word_g`, `word_r`) are serialized independently, each onto its own pair output.
- R7: A data input value that is present only in slots 0 to 3 has no effect on any output. Only the value sampled at the end of slot 4 is sent.
- R8: Raising `rst` in the middle of a symbol forces all pairs to `00` on the next fast cycle and restarts framing from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Serializing clock, five times the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| word_b | input | 10 | Encoded blue-lane symbol, pixel domain |
| word_g | input | 10 | Encoded green-lane symbol, pixel domain |
| word_r | input | 10 | Encoded red-lane symbol, pixel domain |
| pair_b | output | 2 | Blue-lane bit pair; bit 0 rising slot, bit 1 falling slot |
| pair_g | output | 2 | Green-lane bit pair |
| pair_r | output | 2 | Red-lane bit pair |
| pair_clk | output | 2 | Clock-lane bit pair |

## Verification
A word applied to the inputs is due on the pairs in the five fast cycles after the load edge at the end of slot 4. That is one pixel period later, bit pairs 2k/2k+1 in slot k. After reset is released, zeros are due for four cycles and the first word appears in the fifth. The bench drives and samples only on falling edges. It tracks its own slot position, starting from the reset release. Each pair is compared with the word the bench applied in the previous period and rebuilt from it, and this includes periods in which the inputs carry garbage during slots 1 and 2. After a reset in mid-symbol, zeros are due at the very next sample.

// File: rtl/tmds_ddr_serializer.sv
module tmds_ddr_serializer #(
  parameter int WORD_W = 10
) (
  input  logic              clk_fast,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_b,
  input  logic [WORD_W-1:0] word_g,
  input  logic [WORD_W-1:0] word_r,
  output logic [1:0]        pair_b,
  output logic [1:0]        pair_g,
  output logic [1:0]        pair_r,
  output logic [1:0]        pair_clk
);
  localparam int SLOTS = WORD_W / 2;
  localparam int CW    = $clog2(SLOTS);
  localparam int LANES = 4;
  localparam logic [CW-1:0]     LAST    = CW'(SLOTS - 1);
  localparam logic [WORD_W-1:0] CLK_PAT = {{SLOTS{1'b1}}, {SLOTS{1'b0}}};

  logic [CW-1:0] slot;
  logic          load;
  assign load = (slot == LAST);

  always_ff @(posedge clk_fast) begin
    if (rst)       slot <= '0;
    else if (load) slot <= '0;
    else           slot <= slot + 1'b1;
  end

  logic [LANES*WORD_W-1:0] src_all;
  logic [LANES*2-1:0]      pairs_all;
  assign src_all = {CLK_PAT, word_r, word_g, word_b};

  for (genvar i = 0; i < LANES; i++) begin : lane
    logic [WORD_W-1:0] sh;
    always_ff @(posedge clk_fast) begin
      if (rst)       sh <= '0;
      else if (load) sh <= src_all[i*WORD_W +: WORD_W];
      else           sh <= sh >> 2;
    end
    assign pairs_all[2*i +: 2] = sh[1:0];
  end

  assign pair_b   = pairs_all[1:0];
  assign pair_g   = pairs_all[3:2];
  assign pair_r   = pairs_all[5:4];
  assign pair_clk = pairs_all[7:6];
endmodule

// File: rtl/tmds_ddr_serializer_chk.sv
module tmds_ddr_serializer_chk #(
  parameter int WORD_W = 10,
  parameter int CW     = 3
) (
  input logic              clk_fast,
  input logic              rst,
  input logic [CW-1:0]     slot,
  input logic [WORD_W-1:0] word_b,
  input logic [WORD_W-1:0] word_g,
  input logic [WORD_W-1:0] word_r,
  input logic [1:0]        pair_b,
  input logic [1:0]        pair_g,
  input logic [1:0]        pair_r,
  input logic [1:0]        pair_clk
);
  localparam logic [CW-1:0] LAST = CW'(WORD_W / 2 - 1);

  a_r8_reset_clears: assert property (@(posedge clk_fast)
    rst |=> (pair_b == 2'b00 && pair_g == 2'b00 && pair_r == 2'b00 &&
             pair_clk == 2'b00 && slot == '0));

  a_r2_wrap: assert property (@(posedge clk_fast) disable iff (rst)
    slot == LAST |=> slot == '0);

  a_r2_step: assert property (@(posedge clk_fast) disable iff (rst)
    slot != LAST |=> slot == $past(slot) + 1'b1);

  a_r4_load_b: assert property (@(posedge clk_fast) disable iff (rst)
    slot == LAST |=> pair_b == $past(word_b[1:0]));

  a_r6_load_g: assert property (@(posedge clk_fast) disable iff (rst)
    slot == LAST |=> pair_g == $past(word_g[1:0]));

  a_r6_load_r: assert property (@(posedge clk_fast) disable iff (rst)
    slot == LAST |=> pair_r == $past(word_r[1:0]));

  a_r5_clk_low_half: assert property (@(posedge clk_fast) disable iff (rst)
    slot <= CW'(1) |-> pair_clk == 2'b00);

  a_r5_clk_high_half: assert property (@(posedge clk_fast) disable iff (rst)
    slot >= CW'(3) |-> (pair_clk == 2'b11 || pair_clk == 2'b00));
endmodule

bind tmds_ddr_serializer tmds_ddr_serializer_chk #(.WORD_W(WORD_W), .CW(CW)) chk_i (
  .clk_fast(clk_fast), .rst(rst), .slot(slot),
  .word_b(word_b), .word_g(word_g), .word_r(word_r),
  .pair_b(pair_b), .pair_g(pair_g), .pair_r(pair_r), .pair_clk(pair_clk)
);

// File: tb/tmds_ddr_serializer_tb_top.sv
`timescale 1ns/1ps
module tmds_ddr_serializer_tb_top;
  localparam logic [9:0] CLK_PAT = 10'b1111100000;

  logic clk_fast = 1'b0;
  logic rst = 1'b1;
  logic [9:0] word_b = '0, word_g = '0, word_r = '0;
  logic [1:0] pair_b, pair_g, pair_r, pair_clk;
  logic [9:0] eb, eg, er;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk_fast = ~clk_fast;

  tmds_ddr_serializer dut_i (
    .clk_fast(clk_fast), .rst(rst),
    .word_b(word_b), .word_g(word_g), .word_r(word_r),
    .pair_b(pair_b), .pair_g(pair_g), .pair_r(pair_r), .pair_clk(pair_clk)
  );

  function automatic logic [1:0] pb(logic [9:0] w, int s);
    return w[2*s +: 2];
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_zero(string req);
    chk(req, pair_b, 2'b00); chk(req, pair_g, 2'b00);
    chk(req, pair_r, 2'b00); chk(req, pair_clk, 2'b00);
  endtask

  task automatic set_words(logic [9:0] b, logic [9:0] g, logic [9:0] r);
    word_b = b; word_g = g; word_r = r;
  endtask

  // called at a falling edge with rst high; returns at slot 0 of first symbol
  task automatic startup(logic [9:0] b, logic [9:0] g, logic [9:0] r);
    set_words(b, g, r);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_fast);
      chk_zero("R1");
    end
    @(negedge clk_fast);
    eb = b; eg = g; er = r;
  endtask

  task automatic period(string req, logic [9:0] b, logic [9:0] g, logic [9:0] r, bit glitch);
    for (int s = 0; s < 5; s++) begin
      chk(req, pair_b, pb(eb, s));
      chk(req, pair_g, pb(eg, s));
      chk(req, pair_r, pb(er, s));
      chk("R5", pair_clk, pb(CLK_PAT, s));
      if (s == 0) set_words(b, g, r);
      else if (glitch && (s == 1 || s == 2))
        set_words(10'($urandom), 10'($urandom), 10'($urandom));
      else if (s == 3) set_words(b, g, r);
      @(negedge clk_fast);
    end
    eb = b; eg = g; er = r;
  endtask

  initial begin
    repeat (200000) @(posedge clk_fast);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_fast);
    chk_zero("R1");
    // R2: first word surfaces exactly at the first wrap
    startup(10'h3A5, 10'h0C3, 10'h1F0);
    // R3: LSB first, even bit in rising slot
    period("R2", 10'h001, 10'h200, 10'h002, 1'b0);
    period("R3", 10'h155, 10'h2AA, 10'h0FF, 1'b0);
    period("R3", 10'h300, 10'h00C, 10'h030, 1'b0);
    // R6: lanes independent (distinct extremes)
    period("R3", 10'h3FF, 10'h000, 10'h3FF, 1'b0);
    period("R6", 10'h000, 10'h3FF, 10'h000, 1'b0);
    // R4: random words, one-period latency
    for (int n = 0; n < 40; n++)
      period("R4", 10'($urandom), 10'($urandom), 10'($urandom), 1'b0);
    // R7: garbage in slots 1-2 ignored
    for (int n = 0; n < 15; n++)
      period("R7", 10'($urandom), 10'($urandom), 10'($urandom), 1'b1);
    period("R7", 10'h000, 10'h000, 10'h000, 1'b1);
    // R8: reset in mid-symbol
    @(negedge clk_fast);
    @(negedge clk_fast);
    rst = 1'b1;
    @(negedge clk_fast);
    chk_zero("R8");
    @(negedge clk_fast);
    chk_zero("R8");
    startup(10'h2D2, 10'h11E, 10'h3C1);
    for (int n = 0; n < 10; n++)
      period("R8", 10'($urandom), 10'($urandom), 10'($urandom), 1'b0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule